// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial-memory protocol engine. When a write transaction opens, the engine hands over the full byte address. The upper bits name a page and stay fixed for the rest of the transaction. The lower bits give the starting position inside a page of `PAGE_BYTES` bytes. Each data byte the engine delivers goes into a local page buffer at the current in-page position. That position then advances and wraps inside the page. A per-byte mask records which positions now hold data.

When the engine reports the closing STOP, the block starts one timed internal write cycle and raises a busy flag. The engine uses busy to refuse the bus. At the last clock of the cycle, every loaded byte is written into the behavioural storage array in a single step. Bytes that were not loaded keep their old contents.

The engine can also reject the transaction in two ways. Write protection is sampled with the first data byte. An abort strobe throws the buffer away, which the engine uses on a repeated START. A registered read port gives the engine access to the stored bytes.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy_o is low and every byte of the storage array reads FFh.
- R2: start_i latches start_addr_i. The upper ADDR_W-5 bits (default page size 32) select the page, and the low 5 bits select the first in-page position. Each accepted data_vld_i stores data_i at the current position, and the position then advances by one.
- R3: After position PAGE_BYTES-1 the position wraps to 0 of the same page. Data never reaches a neighbouring page.
- R4: A later byte loaded at a position that already holds a byte of the same transaction replaces the earlier byte.
- R5: A stop_i that ends a transaction holding at least one loaded byte raises busy_o on the next clock. busy_o then stays high for exactly CYCLE_CLKS clocks. Until busy_o falls, reads return the old contents; afterwards, they return the new bytes.
- R6: The commit changes only the positions loaded in that transaction. All other bytes of the page keep their previous values.
- R7: If wp_i is high on the cycle the first data byte is strobed, the whole transaction is rejected. No byte is stored and no write cycle starts.
- R8: A stop_i with no loaded data byte starts no write cycle.
- R9: abort_i discards the open transaction. A later stop_i then starts no write cycle and changes nothing.
- R10: While busy_o is high, start_i, data_vld_i, stop_i and abort_i are ignored. They neither shorten the cycle nor change any array byte.
- R11: rd_data_o shows the array byte at rd_addr_i one clock after rd_addr_i is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a write transaction and latches start_addr_i |
| start_addr_i | input | ADDR_W | Byte address: page in the upper bits, in-page position in the low bits |
| data_vld_i | input | 1 | Strobe for one data byte |
| data_i | input | 8 | Data byte |
| wp_i | input | 1 | Write protection, sampled with the first data byte |
| stop_i | input | 1 | STOP ends the transaction and requests a commit |
| abort_i | input | 1 | Discards the open transaction |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench sends a burst that starts four bytes before the page end, which checks that the wrap lands at position 0 of the same page. A design that carried into the next page would corrupt that neighbour. A 40-byte burst checks overwrite: a design that kept the first load would leave stale bytes at positions 0 to 7. A single-byte write is compared byte by byte against its whole page, which catches a commit that writes unloaded positions with buffer leftovers.

The bench samples the target during the cycle and counts the busy clocks, which exposes an early commit or a wrong cycle length. It also covers a protected write, an empty STOP, an abort, and traffic sent during busy. A design that gets any of these wrong would start a cycle or alter bytes it must leave alone.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pcc_cycle_timer.sv
module pcc_cycle_timer #(
  parameter int unsigned CYCLE_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (done_o) busy_d = 1'b0;
      else        cnt_d  = cnt_q - 1'b1;
    end else if (go_i) begin
      busy_d = 1'b1;
      cnt_d  = LAST_CNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R5
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o); // R10
endmodule

// File: rtl/pcc_page_buffer.sv
module pcc_page_buffer
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [ADDR_W-1:0]                start_addr_i,
  input  logic                             data_vld_i,
  input  byte_t                            data_i,
  input  logic                             wp_i,
  input  logic                             stop_i,
  input  logic                             abort_i,
  input  logic                             busy_i,
  input  logic                             done_i,
  output logic                             go_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [PAGE_BYTES-1:0]            mask_o,
  output byte_t [PAGE_BYTES-1:0]           bytes_o
);
  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic                  act_q, act_d;
  logic                  rej_q, rej_d;
  logic                  first_q, first_d;
  logic [OFS_W-1:0]      ofs_q, ofs_d;
  logic [PAGE_W-1:0]     page_q, page_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  byte_t [PAGE_BYTES-1:0] pbuf_q;
  logic                  wr_en;

  always_comb begin
    act_d   = act_q;
    rej_d   = rej_q;
    first_d = first_q;
    ofs_d   = ofs_q;
    page_d  = page_q;
    mask_d  = mask_q;
    wr_en   = 1'b0;
    go_o    = 1'b0;
    if (done_i) mask_d = '0;
    if (!busy_i) begin
      if (abort_i) begin
        act_d  = 1'b0;
        mask_d = '0;
      end else if (start_i) begin
        act_d   = 1'b1;
        rej_d   = 1'b0;
        first_d = 1'b0;
        page_d  = start_addr_i[ADDR_W-1:OFS_W];
        ofs_d   = start_addr_i[OFS_W-1:0];
        mask_d  = '0;
      end else if (stop_i && act_q) begin
        act_d = 1'b0;
        if (!rej_q && (|mask_q)) go_o   = 1'b1;
        else                     mask_d = '0;
      end else if (data_vld_i && act_q && !rej_q) begin
        first_d = 1'b1;
        if (!first_q && wp_i) begin
          rej_d = 1'b1;
        end else begin
          wr_en         = 1'b1;
          mask_d[ofs_q] = 1'b1;
          ofs_d         = ofs_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rej_q   <= 1'b0;
      first_q <= 1'b0;
      ofs_q   <= '0;
      page_q  <= '0;
      mask_q  <= '0;
    end else begin
      act_q   <= act_d;
      rej_q   <= rej_d;
      first_q <= first_d;
      ofs_q   <= ofs_d;
      page_q  <= page_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbuf_q <= '0;
    end else if (wr_en) begin
      pbuf_q[ofs_q] <= data_i;
    end
  end

  assign page_o  = page_q;
  assign mask_o  = mask_q;
  assign bytes_o = pbuf_q;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start_i) |=> $stable(page_q)); // R3
  AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> (mask_q == '0)); // R7
endmodule

// File: rtl/pcc_store.sv
module pcc_store
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  byte_t [PAGE_BYTES-1:0]            bytes_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output byte_t                             rd_data_o
);
  localparam int unsigned OFS_W = $clog2(PAGE_BYTES);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (mask_i[k]) mem_q[{page_i, OFS_W'(k)}] <= bytes_i[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= 8'hFF;
    else        rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned CYCLE_CLKS = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              wp_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic                   go, done;
  logic [PAGE_W-1:0]      page;
  logic [PAGE_BYTES-1:0]  mask;
  byte_t [PAGE_BYTES-1:0] bytes;

  pcc_page_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_buffer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .data_vld_i(data_vld_i), .data_i(data_i), .wp_i(wp_i), .stop_i(stop_i),
    .abort_i(abort_i), .busy_i(busy_o), .done_i(done), .go_o(go),
    .page_o(page), .mask_o(mask), .bytes_o(bytes)
  );

  pcc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .go_i(go), .busy_o(busy_o), .done_o(done)
  );

  pcc_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_store (
    .clk(clk), .rst_n(rst_n), .commit_i(done), .page_i(page), .mask_i(mask),
    .bytes_i(bytes), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  AST_CYCLE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (mask != '0)); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> $stable(mask)); // R6
  AST_PAGE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> $stable(page)); // R10
endmodule

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
  localparam int ADDR_W = 10;
  localparam int PAGE   = 32;
  localparam int CYC    = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  // {addr[31:22], count[21:16], seed[15:8], 7'b0, wp[0]}
  localparam logic [31:0] VEC [6] = '{
    {10'h040, 6'd1,  8'h11, 7'd0, 1'b0},  // R2 R6 single byte
    {10'h05C, 6'd8,  8'h30, 7'd0, 1'b0},  // R3 wrap inside page 2
    {10'h0A0, 6'd40, 8'h50, 7'd0, 1'b0},  // R4 overwrite after wrap
    {10'h3E5, 6'd5,  8'h77, 7'd0, 1'b1},  // R7 protected
    {10'h3FF, 6'd32, 8'h90, 7'd0, 1'b0},  // R3 full page from last position
    {10'h100, 6'd0,  8'h00, 7'd0, 1'b0}   // R8 no data
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, data_vld_i, wp_i, stop_i, abort_i;
  logic [ADDR_W-1:0] start_addr_i, rd_addr_i;
  logic [7:0] data_i, rd_data_o;
  logic busy_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .CYCLE_CLKS(CYC)) i_page_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .data_vld_i(data_vld_i), .data_i(data_i), .wp_i(wp_i), .stop_i(stop_i),
    .abort_i(abort_i), .busy_o(busy_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    rd_addr_i = a;
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic pulse_start(input logic [ADDR_W-1:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    data_vld_i = 1'b1; data_i = d;
    @(negedge clk);
    data_vld_i = 1'b0;
  endtask

  // stop, then count busy clocks; returns count
  task automatic pulse_stop_count(output int n);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_page(input logic [ADDR_W-1:0] a, input string req);
    logic [7:0] v;
    int base;
    base = int'(a) & ~(PAGE - 1);
    for (int k = 0; k < PAGE; k++) begin
      rd(ADDR_W'(base + k), v);
      chk(req, v, model[base + k]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    rst_n = 1'b0; start_i = 0; data_vld_i = 0; wp_i = 0; stop_i = 0; abort_i = 0;
    start_addr_i = '0; data_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", busy_o, 0);
    rd(10'h000, v); chk("R1 byte 000", v, 8'hFF);
    rd(10'h155, v); chk("R1 byte 155", v, 8'hFF);
    rd(10'h3FF, v); chk("R1 R11 byte 3FF", v, 8'hFF);

    // vector walk
    for (int t = 0; t < 6; t++) begin
      logic [ADDR_W-1:0] a;
      int cnt, ofs, base;
      logic [7:0] seed;
      logic prot, exp_cyc;
      a = VEC[t][31:22]; cnt = int'(VEC[t][21:16]); seed = VEC[t][15:8]; prot = VEC[t][0];
      exp_cyc = !prot && cnt > 0;
      base = int'(a) & ~(PAGE - 1);
      ofs = int'(a) & (PAGE - 1);
      rd_addr_i = a;
      pulse_start(a);
      for (int i = 0; i < cnt; i++) begin
        wp_i = (i == 0) ? prot : 1'b0;
        pulse_byte(seed + 8'(i * 7));
        wp_i = 1'b0;
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R5 R7 R8 busy after stop", busy_o, exp_cyc);
      n = 0;
      while (busy_o && n < 1000) begin
        n++;
        if (n == 3) chk("R5 old data during cycle", rd_data_o, model[a]);
        @(negedge clk);
      end
      chk("R5 R7 R8 busy length", n, exp_cyc ? CYC : 0);
      if (exp_cyc) begin
        for (int i = 0; i < cnt; i++)
          model[base + ((ofs + i) % PAGE)] = seed + 8'(i * 7);
      end
      check_page(a, "R2 R3 R4 R6 R7 page contents");
      if (t == 1) check_page(10'h060, "R3 next page untouched");
    end

    // R9 abort discards buffer
    pulse_start(10'h2C4);
    pulse_byte(8'hA1); pulse_byte(8'hA2); pulse_byte(8'hA3);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    pulse_stop_count(n);
    chk("R9 no cycle after abort", n, 0);
    check_page(10'h2C4, "R9 page unchanged");

    // R10 traffic during busy is ignored
    pulse_start(10'h200);
    pulse_byte(8'h5A); pulse_byte(8'hA5);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    n = 1;
    start_i = 1'b1; start_addr_i = 10'h240; @(negedge clk); start_i = 1'b0; n++;
    pulse_byte(8'h01); n++;
    pulse_byte(8'h02); n++;
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0; n++;
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; n++;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R10 cycle length unaffected", n - 1, CYC);
    model[10'h200] = 8'h5A; model[10'h201] = 8'hA5;
    check_page(10'h200, "R10 R5 first write committed");
    check_page(10'h240, "R10 busy traffic ignored");
    pulse_stop_count(n);
    chk("R10 R8 late stop starts nothing", n, 0);

    // R4 overwrite within one page from a mid-page start, then R6 neighbours
    pulse_start(10'h30F);
    for (int i = 0; i < 33; i++) pulse_byte(8'(i + 1));
    pulse_stop_count(n);
    chk("R5 busy length overwrite", n, CYC);
    for (int i = 0; i < 33; i++) model[10'h300 + ((15 + i) % PAGE)] = 8'(i + 1);
    check_page(10'h300, "R4 overwrite at start position");
    rd(10'h30F, v); chk("R4 R11 final byte at start", v, 8'd33);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule